// File: doc/BRIEF.md
# Buffered Output-Compare Channel Pair

This block holds a free-running up-counter and two output-compare channels. Each channel has its own compare value and its own action code, and each drives a pin. When the channels run on their own, each pin toggles, clears or sets at the cycle its compare value is reached. A register bus with single-cycle writes loads the modulus, both compare values, both channel control words and a small general-purpose pin register.

Setting the link bit in channel 0's control word joins the pair into one buffered channel that drives pin 0 only. The two compare registers then take turns in control. Software writes the register that is not in use. The switch to that register happens at the next counter wrap, so the compare point never moves in the middle of a period. While linked, pin 1 is released and follows the general-purpose data and direction bits.

Top module: `bocp_timer`

## Requirements
- R1: The counter runs 0,1,...,M and then back to 0, where M is the modulus register (address 0). The `ovf_o` output is high for exactly the cycles in which the count is 0 after a wrap.
- R2: With the link bit clear, pin 0 follows compare value 0 and action 0, and pin 1 follows compare value 1 and action 1, each on its own. `pin1_oe_o` is 1.
- R3: The action field is bits [2:1] of a control word: 00 no change, 01 toggle, 10 clear, 11 set. It is applied in the cycle after the count equals the compare value.
- R4: Bit 0 of the channel 0 control word (address 1) is the link bit. Once it is set, compare value 0 (address 2) controls pin 0 and `sel_o` reads 0.
- R5: In linked mode, a write to compare value 1 (address 4) moves control to it at the next wrap, not before. A write issued in the wrap cycle itself waits for the following wrap.
- R6: At each wrap, control goes to whichever compare register (address 2 or 4) was written last. If both are written within one period, only the later write counts.
- R7: In linked mode, the channel 1 control word (address 3) has no effect. Pin 1 holds the data bit (bit 0) and `pin1_oe_o` holds the direction bit (bit 1) of the pin register (address 5).
- R8: Clearing the link bit discards any pending switch. Setting it again starts with compare value 0 in control.
- R9: After reset the count, compare values and modulus are 0, linking is off, both pins are low, `sel_o` is 0 and `ovf_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 modulus, 1 ctl0, 2 cmp0, 3 ctl1, 4 cmp1, 5 pin register) |
| wr_data | input | CNT_W | Write data |
| pin0_o | output | 1 | Channel 0 compare output; the buffered output when linked |
| pin1_o | output | 1 | Channel 1 compare output, or the general-purpose data bit when linked |
| pin1_oe_o | output | 1 | Pin 1 output enable |
| ovf_o | output | 1 | Counter overflow pulse |
| sel_o | output | 1 | Compare register in control (0 or 1) |

## Verification
Two cases are the hardest to reach from the ports. The first is a compare write that lands exactly in the wrap cycle. The second is two compare writes within one period, with both orders tried. The stimulus keeps the modulus small, at most 15, and writes at random on about a quarter of the cycles, so both timings occur many times. Directed sequences then wait on `ovf_o` to place writes on each side of a wrap. A cycle model in the bench predicts every output on every cycle, and directed checks confirm the commit point and the last-writer rule.

// File: rtl/bocp_pkg.sv
package bocp_pkg;
  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_SET    = 2'b11
  } oc_act_e;

  localparam logic [2:0] ADR_MOD  = 3'd0;
  localparam logic [2:0] ADR_CTL0 = 3'd1;
  localparam logic [2:0] ADR_CMP0 = 3'd2;
  localparam logic [2:0] ADR_CTL1 = 3'd3;
  localparam logic [2:0] ADR_CMP1 = 3'd4;
  localparam logic [2:0] ADR_GPIO = 3'd5;

  function automatic logic apply_act(oc_act_e a, logic cur);
    case (a)
      ACT_TOGGLE: return ~cur;
      ACT_CLEAR:  return 1'b0;
      ACT_SET:    return 1'b1;
      default:    return cur;
    endcase
  endfunction
endpackage

// File: rtl/bocp_counter.sv
module bocp_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] mod_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;
  logic             wrap;

  always_comb begin
    wrap  = (cnt_q == mod_i);
    cnt_d = wrap ? '0 : cnt_q + CNT_W'(1);
    ovf_d = wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = wrap;
  assign ovf_o  = ovf_q;

  // R1: a wrap restarts the count at zero and raises the pulse
  a_r1_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == mod_i) |=> (cnt_q == '0) && ovf_q);
  // R1: the pulse only appears with a zero count
  a_r1_ovf_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> (cnt_q == '0));
endmodule

// File: rtl/bocp_select.sv
module bocp_select (
  input  logic clk,
  input  logic rst_n,
  input  logic link_i,
  input  logic wrap_i,
  input  logic wr0_i,
  input  logic wr1_i,
  output logic sel_o
);
  logic act_q, act_d;
  logic last_q, last_d;

  always_comb begin
    if (!link_i)     act_d = 1'b0;
    else if (wrap_i) act_d = last_q;
    else             act_d = act_q;

    if (!link_i)     last_d = 1'b0;
    else if (wr1_i)  last_d = 1'b1;
    else if (wr0_i)  last_d = 1'b0;
    else             last_d = last_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      last_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      last_q <= last_d;
    end
  end

  assign sel_o = act_q;

  // R5: control never changes between wraps while linked
  a_r5_commit_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (link_i && !wrap_i) |=> (act_q == $past(act_q)));
  // R6: a wrap hands control to the last written register
  a_r6_last_writer: assert property (@(posedge clk) disable iff (!rst_n)
    (link_i && wrap_i) |=> (act_q == $past(last_q)));
  // R8: unlinked operation clears both the choice and the pending switch
  a_r8_discard: assert property (@(posedge clk) disable iff (!rst_n)
    !link_i |=> (!act_q && !last_q));
endmodule

// File: rtl/bocp_oc_pin.sv
module bocp_oc_pin
  import bocp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  oc_act_e          act_i,
  output logic             pin_o
);
  logic pin_q, pin_d;
  logic hit;

  always_comb begin
    hit   = en_i && (cnt_i == cmp_i);
    pin_d = hit ? apply_act(act_i, pin_q) : pin_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_d;
  end

  assign pin_o = pin_q;

  // R3: set and clear actions land one cycle after the match
  a_r3_set: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && cnt_i == cmp_i && act_i == ACT_SET) |=> pin_q);
  a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && cnt_i == cmp_i && act_i == ACT_CLEAR) |=> !pin_q);
  // R3: without a match the pin holds
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_i && cnt_i == cmp_i) |=> $stable(pin_q));
endmodule

// File: rtl/bocp_timer.sv
module bocp_timer
  import bocp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic             pin0_o,
  output logic             pin1_o,
  output logic             pin1_oe_o,
  output logic             ovf_o,
  output logic             sel_o
);
  localparam int NCH = 2;

  logic [CNT_W-1:0] mod_q, mod_d;
  logic [CNT_W-1:0] cmp_q [NCH];
  logic [CNT_W-1:0] cmp_d [NCH];
  oc_act_e          act_q [NCH];
  oc_act_e          act_d [NCH];
  logic             link_q, link_d;
  logic             gdat_q, gdat_d, gdir_q, gdir_d;

  logic [CNT_W-1:0] cnt;
  logic             wrap;
  logic             sel;
  logic             wr_cmp0, wr_cmp1;
  logic [CNT_W-1:0] pin_cmp [NCH];
  logic             pin_en  [NCH];
  logic             pin_val [NCH];

  always_comb begin
    mod_d  = mod_q;
    cmp_d  = cmp_q;
    act_d  = act_q;
    link_d = link_q;
    gdat_d = gdat_q;
    gdir_d = gdir_q;
    if (wr_en) begin
      case (wr_addr)
        ADR_MOD:  mod_d = wr_data;
        ADR_CTL0: begin
          link_d   = wr_data[0];
          act_d[0] = oc_act_e'(wr_data[2:1]);
        end
        ADR_CMP0: cmp_d[0] = wr_data;
        ADR_CTL1: act_d[1] = oc_act_e'(wr_data[2:1]);
        ADR_CMP1: cmp_d[1] = wr_data;
        ADR_GPIO: begin
          gdat_d = wr_data[0];
          gdir_d = wr_data[1];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_q  <= '0;
      link_q <= 1'b0;
      gdat_q <= 1'b0;
      gdir_q <= 1'b0;
      for (int i = 0; i < NCH; i++) begin
        cmp_q[i] <= '0;
        act_q[i] <= ACT_NONE;
      end
    end else begin
      mod_q  <= mod_d;
      link_q <= link_d;
      gdat_q <= gdat_d;
      gdir_q <= gdir_d;
      for (int i = 0; i < NCH; i++) begin
        cmp_q[i] <= cmp_d[i];
        act_q[i] <= act_d[i];
      end
    end
  end

  assign wr_cmp0 = wr_en && (wr_addr == ADR_CMP0);
  assign wr_cmp1 = wr_en && (wr_addr == ADR_CMP1);

  bocp_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .mod_i(mod_q),
    .cnt_o(cnt), .wrap_o(wrap), .ovf_o(ovf_o)
  );

  bocp_select u_sel (
    .clk(clk), .rst_n(rst_n), .link_i(link_q), .wrap_i(wrap),
    .wr0_i(wr_cmp0), .wr1_i(wr_cmp1), .sel_o(sel)
  );

  // pin 0 compares against the active register when linked; pin 1 freezes
  always_comb begin
    pin_cmp[0] = (link_q && sel) ? cmp_q[1] : cmp_q[0];
    pin_en[0]  = 1'b1;
    pin_cmp[1] = cmp_q[1];
    pin_en[1]  = !link_q;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_pin
    bocp_oc_pin #(.CNT_W(CNT_W)) u_pin (
      .clk(clk), .rst_n(rst_n), .en_i(pin_en[g]),
      .cnt_i(cnt), .cmp_i(pin_cmp[g]), .act_i(act_q[g]),
      .pin_o(pin_val[g])
    );
  end

  assign pin0_o    = pin_val[0];
  assign pin1_o    = link_q ? gdat_q : pin_val[1];
  assign pin1_oe_o = link_q ? gdir_q : 1'b1;
  assign sel_o     = sel;

  // R7: the channel 1 compare output stays frozen while linked
  a_r7_ch1_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    link_q |=> $stable(pin_val[1]));
  // R4: with link off the selection reads channel 0 one cycle later
  a_r4_unlinked_sel: assert property (@(posedge clk) disable iff (!rst_n)
    !link_q |=> !sel_o);
endmodule

// File: tb/test_bocp_timer.sv
module test_bocp_timer;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [2:0]       wr_addr = '0;
  logic [CNT_W-1:0] wr_data = '0;
  logic pin0_o, pin1_o, pin1_oe_o, ovf_o, sel_o;

  int n_chk = 0, n_bad = 0, cyc_n = 0;

  bocp_timer #(.CNT_W(CNT_W)) i_bocp_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pin0_o(pin0_o), .pin1_o(pin1_o), .pin1_oe_o(pin1_oe_o), .ovf_o(ovf_o), .sel_o(sel_o)
  );

  always #2.5 clk = ~clk;

  // cycle model of the requirements
  logic [CNT_W-1:0] m_cnt, m_mod, m_cmp0, m_cmp1;
  logic [1:0] m_a0, m_a1;
  logic m_link, m_gdat, m_gdir, m_act, m_last, m_o0, m_o1, m_ovf;
  logic w, n_o0, n_o1, n_act, n_last;
  logic [CNT_W-1:0] cv;

  function automatic logic do_act(logic [1:0] a, logic cur);
    case (a)
      2'b01: return ~cur;
      2'b10: return 1'b0;
      2'b11: return 1'b1;
      default: return cur;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = '0; m_mod = '0; m_cmp0 = '0; m_cmp1 = '0; m_a0 = 2'b00; m_a1 = 2'b00;
      m_link = 1'b0; m_gdat = 1'b0; m_gdir = 1'b0; m_act = 1'b0; m_last = 1'b0;
      m_o0 = 1'b0; m_o1 = 1'b0; m_ovf = 1'b0;
    end else begin
      w = (m_cnt == m_mod);
      if (m_link) begin
        cv = m_act ? m_cmp1 : m_cmp0;
        n_o0 = (m_cnt == cv) ? do_act(m_a0, m_o0) : m_o0;
        n_o1 = m_o1;
      end else begin
        n_o0 = (m_cnt == m_cmp0) ? do_act(m_a0, m_o0) : m_o0;
        n_o1 = (m_cnt == m_cmp1) ? do_act(m_a1, m_o1) : m_o1;
      end
      n_act  = !m_link ? 1'b0 : (w ? m_last : m_act);
      n_last = !m_link ? 1'b0 : (wr_en && wr_addr == 3'd4) ? 1'b1 :
               (wr_en && wr_addr == 3'd2) ? 1'b0 : m_last;
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_mod = wr_data;
          3'd1: begin m_link = wr_data[0]; m_a0 = wr_data[2:1]; end
          3'd2: m_cmp0 = wr_data;
          3'd3: m_a1 = wr_data[2:1];
          3'd4: m_cmp1 = wr_data;
          3'd5: begin m_gdat = wr_data[0]; m_gdir = wr_data[1]; end
          default: ;
        endcase
      end
      m_cnt = w ? '0 : m_cnt + CNT_W'(1);
      m_ovf = w;
      m_o0 = n_o0; m_o1 = n_o1; m_act = n_act; m_last = n_last;
    end
  end

  task automatic chk(logic got, logic exp, string tag);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: got %b expected %b", tag, cyc_n, got, exp);
    end
  endtask

  task automatic cmp_all();
    chk(ovf_o, m_ovf, "R1 ovf");
    chk(pin0_o, m_o0, m_link ? "R4 pin0" : "R2 pin0");
    chk(sel_o, m_act, "R5 sel");
    chk(pin1_o, m_link ? m_gdat : m_o1, m_link ? "R7 pin1" : "R2 pin1");
    chk(pin1_oe_o, m_link ? m_gdir : 1'b1, m_link ? "R7 oe" : "R2 oe");
  endtask

  // one cycle: check at the falling edge, then drive the inputs
  task automatic cyc(logic en, logic [2:0] a, logic [CNT_W-1:0] d);
    @(negedge clk);
    cyc_n++;
    if (rst_n) cmp_all();
    wr_en = en; wr_addr = a; wr_data = d;
  endtask

  task automatic wait_ovf();
    do cyc(1'b0, 3'd0, '0); while (ovf_o !== 1'b1);
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7717));
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(pin0_o, 1'b0, "R9 pin0");
    chk(pin1_o, 1'b0, "R9 pin1");
    chk(pin1_oe_o, 1'b1, "R9 oe");
    chk(sel_o, 1'b0, "R9 sel");
    chk(ovf_o, 1'b0, "R9 ovf");
    rst_n = 1'b1;

    // R3: unlinked set then clear on channel 0, modulus 9
    cyc(1'b1, 3'd0, 16'd9);
    cyc(1'b1, 3'd2, 16'd3);
    cyc(1'b1, 3'd1, 16'b110);
    repeat (12) cyc(1'b0, 3'd0, '0);
    chk(pin0_o, 1'b1, "R3 set action");
    cyc(1'b1, 3'd1, 16'b100);
    repeat (12) cyc(1'b0, 3'd0, '0);
    chk(pin0_o, 1'b0, "R3 clear action");

    // R4/R5: link, then write cmp1 and watch the commit
    cyc(1'b1, 3'd1, 16'b011);
    cyc(1'b0, 3'd0, '0);
    chk(sel_o, 1'b0, "R4 link starts on ch0");
    wait_ovf();
    cyc(1'b1, 3'd4, 16'd6);
    cyc(1'b0, 3'd0, '0);
    chk(sel_o, 1'b0, "R5 no switch before wrap");
    wait_ovf();
    chk(sel_o, 1'b1, "R5 switch at wrap");

    // R6: both written within one period, cmp0 last
    wait_ovf();
    cyc(1'b1, 3'd4, 16'd5);
    cyc(1'b1, 3'd2, 16'd2);
    wait_ovf();
    chk(sel_o, 1'b0, "R6 last writer ch0");
    cyc(1'b1, 3'd2, 16'd4);
    cyc(1'b1, 3'd4, 16'd8);
    wait_ovf();
    chk(sel_o, 1'b1, "R6 last writer ch1");

    // R7: ch1 control ignored, pin 1 is general purpose
    cyc(1'b1, 3'd3, 16'b110);
    cyc(1'b1, 3'd5, 16'b01);
    cyc(1'b0, 3'd0, '0);
    chk(pin1_o, 1'b1, "R7 gpio data");
    chk(pin1_oe_o, 1'b0, "R7 gpio dir");
    repeat (12) cyc(1'b0, 3'd0, '0);
    chk(pin1_o, 1'b1, "R7 ch1 ctl ignored");

    // R8: pending switch discarded on unlink
    wait_ovf();
    cyc(1'b1, 3'd2, 16'd3);
    wait_ovf();
    cyc(1'b1, 3'd4, 16'd7);
    cyc(1'b1, 3'd1, 16'b010);
    cyc(1'b1, 3'd1, 16'b011);
    wait_ovf();
    chk(sel_o, 1'b0, "R8 pending discarded");

    // random phase
    for (int i = 0; i < 6000; i++) begin
      int r;
      r = $urandom_range(0, 7);
      if (r < 2) begin
        logic [2:0] a;
        logic [CNT_W-1:0] d;
        a = 3'($urandom_range(1, 5));
        d = CNT_W'($urandom_range(0, 15));
        if (a == 3'd1 || a == 3'd3) d = CNT_W'($urandom_range(0, 7) | ($urandom_range(0, 5) == 0 ? 0 : 1));
        cyc(1'b1, a, d);
      end else if (r == 2 && ovf_o === 1'b1) begin
        cyc(1'b1, 3'd0, CNT_W'($urandom_range(3, 15)));
      end else begin
        cyc(1'b0, 3'd0, '0);
      end
    end
    cyc(1'b0, 3'd0, '0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule